// File: doc/BRIEF.md
# Quadrature and Pulse Input Decoder

This block turns two external count lines into clean, clock-synchronous count strobes for a position or event counter that sits beside it. The lines first pass through a synchronizer. Each new sample is then compared with the sample held from the cycle before. The result drives either an up strobe or a down strobe, each one clock wide, and never both at once. A current-direction flag records which way the last count went.

The `mode_updn` input selects how the lines are read. When it is high, the first line carries up pulses and the second carries down pulses. When it is low, the two lines are a phase-shifted pair, A and B. For the phase-shifted pair there are three counting resolutions: one count per signal period, two, or four. A `dir_inv` input swaps the sense of up and down. If both phase lines change in the same sample, the transition is illegal. Such a step counts nothing and sets a sticky abnormal-input flag. The flag stays set until reset or until `err_clr` is asserted.

Quadrature signals can be decoded reliably up to a quarter of the clock rate. Pulse lines can be decoded up to half the clock rate. The counter that consumes the strobes and any register access are outside this block.

Top module: `quad_pulse_decoder`

## Requirements
- R1: With `mode_updn`=1, each rising edge on `line_a` gives one `cnt_up` strobe and each rising edge on `line_b` gives one `cnt_dn` strobe. Falling edges give nothing. `cnt_up` and `cnt_dn` are never high in the same cycle.
- R2: With `mode_updn`=0 and `edge_sel`=2'b10 (or 2'b11), every legal one-line change of the pair {A,B} counts. The sequence 00→10→11→01→00 counts up, and its reverse counts down.
- R3: With `edge_sel`=2'b00, only the step between {A,B}=00 and 10 counts: 00→10 counts up and 10→00 counts down. All other legal steps give no strobe.
- R4: With `edge_sel`=2'b01, every change of A while B is steady counts, with the direction given in R2. Changes of B give no strobe.
- R5: `dir_inv`=1 swaps up and down strobes in both modes.
- R6: In quadrature mode, a step where A and B change in the same sample (00↔11, 01↔10) produces no strobe and sets `abn_flag`.
- R7: `abn_flag` stays high until `rst_n` is low or `err_clr` is high for a clock. If a new abnormal step arrives in the same cycle as `err_clr`, the set wins. Pulse mode never sets `abn_flag`.
- R8: In pulse mode, rising edges on both lines in the same sample cancel, and no strobe is issued.
- R9: A strobe appears on the third rising clock edge after an input change and lasts one cycle. A quadrature state held for a single clock is still counted.
- R10: `dir_flag` goes to 1 with each `cnt_dn` and to 0 with each `cnt_up`. It holds its value otherwise.
- R11: While `rst_n` is low, `cnt_up`, `cnt_dn`, `dir_flag` and `abn_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_updn | input | 1 | 1: up/down pulse lines; 0: phase A/B pair |
| line_a | input | 1 | Phase A or up pulse line (asynchronous) |
| line_b | input | 1 | Phase B or down pulse line (asynchronous) |
| edge_sel | input | 2 | Quadrature resolution: 00 x1, 01 x2, 10/11 x4 |
| dir_inv | input | 1 | Swap up and down |
| err_clr | input | 1 | Clear the abnormal-input flag |
| cnt_up | output | 1 | One-cycle up count strobe |
| cnt_dn | output | 1 | One-cycle down count strobe |
| dir_flag | output | 1 | Direction of last count (1 = down) |
| abn_flag | output | 1 | Sticky abnormal-input flag |

## Verification
If the held previous sample is wrong, the fault shows at the ports three edges after the next input change. It appears as a strobe on the wrong line, a missing strobe, or an extra strobe, and the bench walks every legal and illegal step to expose this. A fault in the abnormal flag shows either as a flag that drops without a clear or reset, or as a strobe issued on an illegal step. The sticky and clear checks catch this within one cycle of the event. A wrong direction register shows up in the first strobe cycle as a mismatch against `dir_flag`.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

  // Resolution of quadrature counting
  typedef enum logic [1:0] {
    EV_X1  = 2'b00,
    EV_X2  = 2'b01,
    EV_X4  = 2'b10,
    EV_X4B = 2'b11
  } edge_eval_e;

  // One evaluated step of the input pair
  typedef struct packed {
    logic up;
    logic dn;
    logic abn;
  } step_t;

  localparam int unsigned LINES = 2;

endpackage

// File: rtl/qpd_sync.sv
module qpd_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  // next-state: shift the chain by one stage
  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qpd_quad_eval.sv
module qpd_quad_eval
  import qpd_pkg::*;
(
  input  logic [1:0]  prev_ab,   // {A,B} previous sample
  input  logic [1:0]  cur_ab,    // {A,B} current sample
  input  edge_eval_e  edge_sel,
  input  logic        dir_inv,
  output step_t       step
);

  logic a_chg, b_chg, cw, qual;

  always_comb begin
    a_chg = prev_ab[1] ^ cur_ab[1];
    b_chg = prev_ab[0] ^ cur_ab[0];
    // clockwise: A change with new A != B, or B change with new B == A
    if (a_chg) cw = cur_ab[1] ^ cur_ab[0];
    else       cw = ~(cur_ab[1] ^ cur_ab[0]);
    unique case (edge_sel)
      EV_X1:   qual = a_chg & ~b_chg & ~cur_ab[0];
      EV_X2:   qual = a_chg & ~b_chg;
      default: qual = a_chg ^ b_chg;
    endcase
    step.abn = a_chg & b_chg;
    step.up  = qual & (cw ^ dir_inv);
    step.dn  = qual & ~(cw ^ dir_inv);
  end

endmodule

// File: rtl/qpd_pulse_eval.sv
module qpd_pulse_eval
  import qpd_pkg::*;
(
  input  logic [1:0] prev_ud,   // {up,down} previous sample
  input  logic [1:0] cur_ud,    // {up,down} current sample
  input  logic       dir_inv,
  output step_t      step
);

  logic up_rise, dn_rise, net;

  always_comb begin
    up_rise  = cur_ud[1] & ~prev_ud[1];
    dn_rise  = cur_ud[0] & ~prev_ud[0];
    net      = up_rise ^ dn_rise;   // coincident edges cancel
    step.abn = 1'b0;
    step.up  = net & (up_rise ^ dir_inv);
    step.dn  = net & ~(up_rise ^ dir_inv);
  end

endmodule

// File: rtl/quad_pulse_decoder.sv
module quad_pulse_decoder
  import qpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_updn,
  input  logic       line_a,
  input  logic       line_b,
  input  logic [1:0] edge_sel,
  input  logic       dir_inv,
  input  logic       err_clr,
  output logic       cnt_up,
  output logic       cnt_dn,
  output logic       dir_flag,
  output logic       abn_flag
);

  logic [LINES-1:0] raw_in, smp_cur, smp_prev_q;
  step_t            quad_step, pulse_step, sel_step;
  logic             up_d, dn_d, dir_d, abn_d;
  logic             up_q, dn_q, dir_q, abn_q;

  assign raw_in = {line_a, line_b};

  qpd_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (smp_cur)
  );

  qpd_quad_eval u_quad (
    .prev_ab  (smp_prev_q),
    .cur_ab   (smp_cur),
    .edge_sel (edge_eval_e'(edge_sel)),
    .dir_inv  (dir_inv),
    .step     (quad_step)
  );

  qpd_pulse_eval u_pulse (
    .prev_ud (smp_prev_q),
    .cur_ud  (smp_cur),
    .dir_inv (dir_inv),
    .step    (pulse_step)
  );

  // next-state
  always_comb begin
    sel_step = mode_updn ? pulse_step : quad_step;
    up_d     = sel_step.up;
    dn_d     = sel_step.dn;
    abn_d    = sel_step.abn | (abn_q & ~err_clr);
    if (sel_step.dn)      dir_d = 1'b1;
    else if (sel_step.up) dir_d = 1'b0;
    else                  dir_d = dir_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_prev_q <= '0;
      up_q       <= 1'b0;
      dn_q       <= 1'b0;
      dir_q      <= 1'b0;
      abn_q      <= 1'b0;
    end else begin
      smp_prev_q <= smp_cur;
      up_q       <= up_d;
      dn_q       <= dn_d;
      dir_q      <= dir_d;
      abn_q      <= abn_d;
    end
  end

  assign cnt_up   = up_q;
  assign cnt_dn   = dn_q;
  assign dir_flag = dir_q;
  assign abn_flag = abn_q;

  // R1
  updn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn));

  // R6
  abn_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abn_flag) |-> (!cnt_up && !cnt_dn));

  // R7
  abn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abn_flag && !err_clr) |=> abn_flag);

  // R7
  abn_pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abn_flag && mode_updn) |=> !abn_flag);

  // R10
  dir_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dn |-> dir_flag);

  // R10
  dir_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_up |-> !dir_flag);

endmodule

// File: tb/quad_pulse_decoder_test.sv
`timescale 1ns/1ps
module quad_pulse_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_updn, line_a, line_b, dir_inv, err_clr;
  logic [1:0] edge_sel;
  logic       cnt_up, cnt_dn, dir_flag, abn_flag;

  int tests = 0;
  int fails = 0;
  bit dexp  = 1'b0;

  always #4 clk = ~clk;

  quad_pulse_decoder uut (
    .clk(clk), .rst_n(rst_n), .mode_updn(mode_updn),
    .line_a(line_a), .line_b(line_b), .edge_sel(edge_sel),
    .dir_inv(dir_inv), .err_clr(err_clr),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .dir_flag(dir_flag), .abn_flag(abn_flag)
  );

  // {mode, edge_sel[1:0], dir_inv, a, b, exp_up, exp_dn, exp_abn}
  localparam int NV = 39;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_10_0_10_100, 9'b0_10_0_11_100, 9'b0_10_0_01_100, 9'b0_10_0_00_100,
    9'b0_10_0_01_010, 9'b0_10_0_11_010, 9'b0_10_0_10_010, 9'b0_10_0_00_010,
    9'b0_00_0_10_100, 9'b0_00_0_11_000, 9'b0_00_0_01_000, 9'b0_00_0_00_000,
    9'b0_00_0_01_000, 9'b0_00_0_11_000, 9'b0_00_0_10_000, 9'b0_00_0_00_010,
    9'b0_01_0_10_100, 9'b0_01_0_11_000, 9'b0_01_0_01_100, 9'b0_01_0_00_000,
    9'b0_01_0_01_000, 9'b0_01_0_11_010, 9'b0_01_0_10_000, 9'b0_01_0_00_010,
    9'b0_10_1_10_010, 9'b0_10_1_00_100,
    9'b0_10_0_11_001, 9'b0_10_0_00_001, 9'b0_10_0_10_101,
    9'b1_00_0_00_001, 9'b1_00_0_10_101, 9'b1_00_0_00_001, 9'b1_00_0_01_011,
    9'b1_00_0_11_101, 9'b1_00_0_00_001,
    9'b1_00_0_11_001, 9'b1_00_0_00_001,
    9'b1_00_1_10_011, 9'b1_00_0_01_011
  };

  function automatic string tag_of(int i);
    if (i < 8)  return "R2";
    if (i < 16) return "R3";
    if (i < 24) return "R4";
    if (i < 26) return "R5";
    if (i < 29) return "R6";
    if (i < 35) return "R1";
    if (i < 37) return "R8";
    return "R5";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ups, dns;
    logic [1:0] burst [4];
    rst_n = 1'b0; mode_updn = 1'b0; line_a = 1'b0; line_b = 1'b0;
    edge_sel = 2'b10; dir_inv = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "cnt_up", cnt_up, 0);
    chk("R11", "cnt_dn", cnt_dn, 0);
    chk("R11", "dir_flag", dir_flag, 0);
    chk("R11", "abn_flag", abn_flag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      mode_updn = v[8]; edge_sel = v[7:6]; dir_inv = v[5];
      line_a = v[4]; line_b = v[3];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(tag_of(i), "cnt_up", cnt_up, v[2]);
      chk(tag_of(i), "cnt_dn", cnt_dn, v[1]);
      chk("R7", "abn_flag", abn_flag, v[0]);
      if (v[1]) dexp = 1'b1;
      else if (v[2]) dexp = 1'b0;
      chk("R10", "dir_flag", dir_flag, dexp);
      @(negedge clk);
      chk("R9", "strobe width", {cnt_up, cnt_dn}, 0);
    end

    // R7 clear request drops the flag
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R7", "abn after clear", abn_flag, 0);

    // R7 pulse mode, both lines change: no abnormal, a rising counts up
    line_a = 1'b1; line_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "abn in pulse mode", abn_flag, 0);
    chk("R1", "cnt_up on a rise", cnt_up, 1);

    // R9 quadrature burst, one state per clock, x4
    mode_updn = 1'b0; edge_sel = 2'b10;
    repeat (4) @(negedge clk);
    burst = '{2'b11, 2'b01, 2'b00, 2'b10};
    ups = 0; dns = 0;
    for (int k = 0; k < 12; k++) begin
      ups += int'(cnt_up);
      dns += int'(cnt_dn);
      if (k < 4) begin
        line_a = burst[k][1]; line_b = burst[k][0];
      end
      @(negedge clk);
    end
    chk("R9", "burst up count", ups, 4);
    chk("R9", "burst down count", dns, 0);

    // R6 abnormal again, then R11 reset clears it
    line_a = 1'b0; line_b = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", "abn set", abn_flag, 1);
    chk("R6", "no strobe", {cnt_up, cnt_dn}, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "abn in reset", abn_flag, 0);
    chk("R11", "dir in reset", dir_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule